// File: doc/BRIEF.md
# Repeated-Addition Sequencer

This block forms a product by repeated addition under the control of a small algorithmic state machine. A start pulse moves it from rest into a capture state. That state latches three unsigned operands: an initial accumulator value, an addend and an iteration count. The machine then alternates between a test step and an add step. Each add step adds the addend into the accumulator and lowers the count by one, and this goes on until the count reaches zero.

When the loop ends, the machine parks in a terminal state that loops on itself. There it presents the accumulator on the result port, together with a valid flag, but only when the accumulator is above a fixed threshold of 25. Below or at the threshold, the result port reads zero. A further start pulse seen in the terminal state runs the sequence again with fresh operands. The busy flag marks the capture, test and add states, and a start that arrives while busy has no effect.

Top module: `rpt_add_top`

## Requirements
- R1: While rst_n is low, and on the first sample after it is released, busy, result_vld and result are all zero.
- R2: A start pulse sampled at rest makes busy read one from the next cycle on.
- R3: The operands are captured in the cycle after the accepted start. If the captured count is zero, the machine finishes with the accumulator equal to opnd_a.
- R4: The final accumulator equals (opnd_a + opnd_b * opnd_n) mod 2^16, with all operands taken as unsigned.
- R5: Busy stays high for exactly 2*opnd_n + 2 cycles after the accepted start: one capture cycle, two cycles per addition and one final test.
- R6: In the terminal state, result equals the accumulator and result_vld is one when the accumulator is greater than 25. Otherwise result is zero and result_vld is zero.
- R7: In the terminal state with start low, result and result_vld hold their values from cycle to cycle.
- R8: A start pulse in the terminal state begins a new run with newly captured operands, with the same latency and result rules as a run started from rest.
- R9: A start pulse while busy is ignored: neither the result nor the latency of the run in progress changes.
- R10: result_vld is never high while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released on a clock edge |
| start | input | 1 | One-cycle request to run |
| opnd_a | input | 8 | Initial accumulator value |
| opnd_b | input | 8 | Addend |
| opnd_n | input | 8 | Number of additions |
| result | output | 16 | Accumulator when above threshold in the terminal state, else zero |
| result_vld | output | 1 | High in the terminal state while the accumulator exceeds 25 |
| busy | output | 1 | High during capture, test and add states |

## Verification
The assertions take for granted that the operands are steady during the capture cycle that follows an accepted start. They also take for granted that reset is released on a clock edge. The bench meets both conditions: it drives every input at the falling edge, and it changes operands only while the machine is at rest, in the terminal state or already past capture. The one exception is a deliberate start pulse during a busy run, which carries different operands to show they are not taken. The sweeps cover counts of zero and of full scale, and accumulator values on both sides of the threshold.

// File: rtl/rpt_add_pkg.sv
package rpt_add_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LOAD = 3'd1,
    ST_TEST = 3'd2,
    ST_ADD  = 3'd3,
    ST_DONE = 3'd4
  } seq_state_t;

  function automatic logic is_busy(input seq_state_t s);
    return (s == ST_LOAD) || (s == ST_TEST) || (s == ST_ADD);
  endfunction

endpackage

// File: rtl/rpt_add_ctrl.sv
module rpt_add_ctrl
  import rpt_add_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       cnt_pos,
  output seq_state_t state,
  output logic       ld_en,
  output logic       add_en,
  output logic       busy
);

  seq_state_t state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: if (start) state_nx = ST_LOAD;
      ST_LOAD: state_nx = ST_TEST;
      ST_TEST: state_nx = cnt_pos ? ST_ADD : ST_DONE;
      ST_ADD:  state_nx = ST_TEST;
      ST_DONE: if (start) state_nx = ST_LOAD;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  always_comb begin
    ld_en  = (state == ST_LOAD);
    add_en = (state == ST_ADD);
    busy   = is_busy(state);
  end

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && start) |=> busy);

  // R3
  zero_count_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TEST && !cnt_pos) |=> (state == ST_DONE));

  // R9
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADD && start) |=> (state == ST_TEST));

endmodule

// File: rtl/rpt_add_dpath.sv
module rpt_add_dpath #(
  parameter int OPW  = 8,
  parameter int ACCW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_en,
  input  logic            add_en,
  input  logic [OPW-1:0]  in_a,
  input  logic [OPW-1:0]  in_b,
  input  logic [OPW-1:0]  in_n,
  output logic [ACCW-1:0] acc,
  output logic            cnt_pos
);

  localparam int PADW = ACCW - OPW;

  logic [ACCW-1:0] b_q;
  logic [OPW-1:0]  cnt_q;
  logic [ACCW-1:0] acc_nx, b_nx;
  logic [OPW-1:0]  cnt_nx;

  always_comb begin
    acc_nx = acc;
    b_nx   = b_q;
    cnt_nx = cnt_q;
    if (ld_en) begin
      acc_nx = {{PADW{1'b0}}, in_a};
      b_nx   = {{PADW{1'b0}}, in_b};
      cnt_nx = in_n;
    end else if (add_en) begin
      acc_nx = acc + b_q;
      cnt_nx = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      b_q   <= '0;
      cnt_q <= '0;
    end else if (ld_en || add_en) begin
      acc   <= acc_nx;
      b_q   <= b_nx;
      cnt_q <= cnt_nx;
    end
  end

  assign cnt_pos = (cnt_q != '0);

  // R4
  acc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    add_en |=> (acc == ACCW'($past(acc) + $past(b_q))));

  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    add_en |=> (cnt_q == OPW'($past(cnt_q) - 1'b1)));

  // R3
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (acc == {{PADW{1'b0}}, $past(in_a)} && cnt_q == $past(in_n)));

endmodule

// File: rtl/rpt_add_outgate.sv
module rpt_add_outgate #(
  parameter int ACCW   = 16,
  parameter int THRESH = 25
) (
  input  logic            done,
  input  logic [ACCW-1:0] acc,
  output logic [ACCW-1:0] result,
  output logic            result_vld
);

  localparam logic [ACCW-1:0] THR = ACCW'(THRESH);

  logic above;

  always_comb begin
    above      = (acc > THR);
    result_vld = done && above;
    result     = result_vld ? acc : '0;
  end

endmodule

// File: rtl/rpt_add_top.sv
module rpt_add_top
  import rpt_add_pkg::*;
#(
  parameter int OPW    = 8,
  parameter int ACCW   = 16,
  parameter int THRESH = 25
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [OPW-1:0]  opnd_a,
  input  logic [OPW-1:0]  opnd_b,
  input  logic [OPW-1:0]  opnd_n,
  output logic [ACCW-1:0] result,
  output logic            result_vld,
  output logic            busy
);

  seq_state_t      state;
  logic            ld_en, add_en, cnt_pos;
  logic [ACCW-1:0] acc;

  rpt_add_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cnt_pos(cnt_pos),
    .state(state), .ld_en(ld_en), .add_en(add_en), .busy(busy)
  );

  rpt_add_dpath #(.OPW(OPW), .ACCW(ACCW)) u_dpath (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .add_en(add_en),
    .in_a(opnd_a), .in_b(opnd_b), .in_n(opnd_n),
    .acc(acc), .cnt_pos(cnt_pos)
  );

  rpt_add_outgate #(.ACCW(ACCW), .THRESH(THRESH)) u_gate (
    .done(state == ST_DONE), .acc(acc),
    .result(result), .result_vld(result_vld)
  );

  // R10
  vld_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && result_vld));

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE && !start) |=> ($stable(result) && $stable(result_vld)));

  // R6
  out_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE) |-> (result_vld == (acc > ACCW'(THRESH))));

endmodule

// File: tb/rpt_add_top_tb.sv
module rpt_add_top_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [7:0]  opnd_a, opnd_b, opnd_n;
  logic [15:0] result;
  logic        result_vld, busy;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;

  always #10 clk = ~clk;

  rpt_add_top u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_n(opnd_n),
    .result(result), .result_vld(result_vld), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // glitch: pulse start with other operands during the busy phase
  task automatic run(input int a, input int b, input int n, input bit glitch);
    int exp_acc, lat, exp_lat;
    bit exp_vld;
    exp_acc = (a + b * n) % 65536;
    exp_vld = exp_acc > 25;
    exp_lat = 2 * n + 2;
    @(negedge clk);
    opnd_a = 8'(a); opnd_b = 8'(b); opnd_n = 8'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2", int'(busy), 1);
    check(result_vld == 1'b0, "R10", int'(result_vld), 0);
    lat = 0;
    while (busy && lat < 1000) begin
      lat++;
      if (glitch && lat == 2) begin
        opnd_a = 8'(a + 7); opnd_b = 8'(b + 3); opnd_n = 8'(n + 5);
        start = 1'b1;
      end else if (glitch && lat == 3) begin
        start = 1'b0;
      end
      if (result_vld) check(1'b0, "R10", 1, 0);
      @(negedge clk);
    end
    check(lat == exp_lat, glitch ? "R9" : "R5", lat, exp_lat);
    check(result_vld == exp_vld, "R6", int'(result_vld), int'(exp_vld));
    check(result == (exp_vld ? 16'(exp_acc) : 16'd0), glitch ? "R9" : "R4",
          int'(result), exp_vld ? exp_acc : 0);
    if (n == 0)
      check(result == (a > 25 ? 16'(a) : 16'd0), "R3", int'(result), a > 25 ? a : 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    int hold_res;
    bit hold_vld;
    int as[6] = '{0, 1, 25, 26, 200, 255};
    int bs[5] = '{0, 1, 12, 13, 255};
    int ns[5] = '{0, 1, 2, 3, 255};
    rst_n = 1'b0; start = 1'b0; opnd_a = '0; opnd_b = '0; opnd_n = '0;
    repeat (3) @(negedge clk);
    check(busy == 0 && result_vld == 0 && result == 0, "R1", int'(result), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && result_vld == 0 && result == 0, "R1", int'(busy), 0);

    // first run from rest, R2 path
    run(30, 0, 0, 0);

    // R7: terminal state holds
    hold_res = int'(result); hold_vld = result_vld;
    repeat (6) @(negedge clk);
    check(result == 16'(hold_res) && result_vld == hold_vld, "R7", int'(result), hold_res);

    // R8: restart from terminal state with a sub-threshold result
    run(5, 2, 3, 0);
    check(result_vld == 1'b0, "R8", int'(result_vld), 0);
    run(10, 4, 5, 0);
    check(result == 16'd30, "R8", int'(result), 30);

    // R3 / R6 threshold sweep with zero count
    for (int a = 0; a <= 40; a++) run(a, 9, 0, 0);
    // threshold crossing through additions
    for (int b = 0; b <= 14; b++) run(0, b, 2, 0);

    // R4 / R5 grid sweep
    foreach (as[i]) foreach (bs[j]) foreach (ns[k]) run(as[i], bs[j], ns[k], 0);

    // R9: start while busy
    run(3, 4, 10, 1);
    run(100, 255, 255, 1);

    // R1: reset during a run
    @(negedge clk);
    opnd_a = 8'd50; opnd_b = 8'd50; opnd_n = 8'd50; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(busy == 0 && result_vld == 0 && result == 0, "R1", int'(busy), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(busy == 0 && result_vld == 0 && result == 0, "R1", int'(result), 0);
    run(26, 0, 0, 0);

    finish_up();
  end

endmodule